// File: doc/BRIEF.md
# Stop-Mode Wake and Recovery Controller

This block runs the low-power STOP state of a small 8-bit microcontroller. The CPU asks to stop with a one-cycle request. The controller then takes a snapshot of the GPIO pins, freezes the port input register and waits for a wake source. A watchdog time-out or a change on an enabled GPIO pin starts a timed recovery. Once recovery ends, the CPU is sent to fetch its start vector. If the watchdog was set to interrupt mode and interrupts are on, a watchdog interrupt follows after that. A low level on the external reset pin or on the debug pin forces a full system reset instead of a recovery.

A status register of three cause flags records why the part woke up. Any read by the CPU clears all three. The vector fetch appears as two consecutive address cycles, low byte then high byte. Because the port register stays frozen until recovery is complete, a pin pulse that is shorter than the delay can wake the part but leaves no mark in the port register and raises no pin interrupt.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset, in_stop, sys_reset, recover_done, wdt_irq, vec_valid and the three status flags are all 0.
- R2: A stop_req pulse while running sets in_stop high on the following cycle and keeps it high until a wake source is seen.
- R3: A wdt_timeout pulse during STOP starts a recovery (sys_reset stays 0) in either watchdog mode, and it sets both stat_wdt and stat_stop.
- R4: wdt_irq pulses once, strictly after recover_done, only when wdt_irq_mode was 1 at wake time and irq_enable is 1. Otherwise it stays 0.
- R5: During STOP, a level change in either direction on a pin whose gpio_wake_en bit is 1 starts a recovery and sets stat_stop with stat_wdt left 0. Changes on pins whose enable bit is 0 do not wake the part.
- R6: During STOP, ext_reset_n low or dbg_n low drives sys_reset high while the pin is held low, with no recover_done. It sets stat_hard and clears stat_stop.
- R7: recover_done pulses for one cycle exactly DELAY cycles after in_stop falls. Wake events that arrive during that delay change neither the timing nor the flags.
- R8: After a recovery, and after sys_reset is released, vec_valid is high for exactly two cycles, with vec_addr 0x0002 and then 0x0003.
- R9: port_in holds its value throughout STOP and recovery and then follows the synchronised pins again. pin_irq pulses for each bit whose latched value changes. A pin pulse that has ended before recovery finishes leaves port_in unchanged and raises no pin_irq.
- R10: A status_rd pulse clears stat_stop, stat_wdt and stat_hard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_req | input | 1 | One-cycle request from the CPU to enter STOP |
| wdt_timeout | input | 1 | One-cycle watchdog time-out event |
| wdt_irq_mode | input | 1 | Watchdog mode: 1 = interrupt, 0 = reset |
| irq_enable | input | 1 | Global interrupt enable |
| gpio_wake_en | input | N_PINS | Per-pin wake enable |
| gpio_pin | input | N_PINS | Asynchronous pin levels |
| ext_reset_n | input | 1 | External reset pin, active low |
| dbg_n | input | 1 | Debug pin, low forces reset |
| status_rd | input | 1 | CPU read of the status register; clears the flags |
| sys_reset | output | 1 | Full system reset |
| recover_done | output | 1 | One-cycle end-of-recovery strobe |
| wdt_irq | output | 1 | One-cycle watchdog interrupt request |
| vec_valid | output | 1 | Start-vector fetch address is valid |
| vec_addr | output | AW | Start-vector fetch address |
| in_stop | output | 1 | Part is in STOP |
| port_in | output | N_PINS | Port input data register |
| pin_irq | output | N_PINS | Per-pin change pulse from the port register |
| stat_stop | output | 1 | Status flag: woke from STOP by recovery |
| stat_wdt | output | 1 | Status flag: watchdog caused the wake |
| stat_hard | output | 1 | Status flag: full reset from a pin |

## Verification
The assertions assume that stop_req, wdt_timeout and status_rd are single-cycle pulses driven synchronously to clk. They also assume the pins start low, so that the reset value of the port register matches them. The bench drives every input a short time after the rising edge, issues each pulse for exactly one cycle and starts the pins low. It holds ext_reset_n and dbg_n low for several cycles, well beyond the two-flop synchroniser. A glitch is a pin held for four cycles, which is long enough to pass the synchroniser and much shorter than the recovery delay.

// File: rtl/swc_pkg.sv
`timescale 1ns/1ps
package swc_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_STOP    = 3'd1,
    ST_RECOVER = 3'd2,
    ST_HRST    = 3'd3,
    ST_VEC0    = 3'd4,
    ST_VEC1    = 3'd5
  } swc_state_e;
endpackage

// File: rtl/swc_sync.sv
`timescale 1ns/1ps
module swc_sync #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= {W{RST_VAL}};
      stage2_q <= {W{RST_VAL}};
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/swc_pin_watch.sv
`timescale 1ns/1ps
module swc_pin_watch #(
  parameter int unsigned N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_s,
  input  logic [N_PINS-1:0] wake_en,
  input  logic              snap_take,
  input  logic              frz,
  output logic              wake_hit,
  output logic [N_PINS-1:0] port_in,
  output logic [N_PINS-1:0] pin_irq
);
  logic [N_PINS-1:0] snap_q, snap_n;
  logic [N_PINS-1:0] port_q, port_n;
  logic [N_PINS-1:0] pirq_q, pirq_n;
  logic [N_PINS-1:0] diff;

  // per-pin change against the snapshot, gated by enable
  for (genvar i = 0; i < N_PINS; i++) begin : g_cmp
    assign diff[i] = (pin_s[i] ^ snap_q[i]) & wake_en[i];
  end
  assign wake_hit = |diff;

  always_comb begin
    snap_n = snap_q;
    port_n = port_q;
    pirq_n = '0;
    if (snap_take) snap_n = pin_s;
    if (!frz) begin
      port_n = pin_s;
      pirq_n = pin_s ^ port_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      port_q <= '0;
      pirq_q <= '0;
    end else begin
      snap_q <= snap_n;
      port_q <= port_n;
      pirq_q <= pirq_n;
    end
  end

  assign port_in = port_q;
  assign pin_irq = pirq_q;

  assert_port_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && $past(frz)) |-> $stable(port_q));
  assert_no_pirq_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frz) |-> (pirq_q == '0));
endmodule

// File: rtl/swc_seq.sv
`timescale 1ns/1ps
module swc_seq
  import swc_pkg::*;
#(
  parameter int unsigned DELAY    = 64,
  parameter int unsigned AW       = 16,
  parameter logic [AW-1:0] VEC_ADDR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_req,
  input  logic          wdt_timeout,
  input  logic          wdt_irq_mode,
  input  logic          irq_enable,
  input  logic          pin_wake,
  input  logic          hard_req,
  output logic          in_stop,
  output logic          frz,
  output logic          snap_take,
  output logic          sys_reset,
  output logic          recover_done,
  output logic          wdt_irq,
  output logic          vec_valid,
  output logic [AW-1:0] vec_addr,
  output logic          ev_wdt,
  output logic          ev_pin,
  output logic          ev_hard
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DELAY - 1);

  swc_state_e st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic pend_q, pend_n;
  logic done_q, done_n;
  logic irq_q, irq_n;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    pend_n  = pend_q;
    done_n  = 1'b0;
    irq_n   = 1'b0;
    ev_wdt  = 1'b0;
    ev_pin  = 1'b0;
    ev_hard = 1'b0;
    if (hard_req) begin
      pend_n = 1'b0;
      if (st_q != ST_HRST) begin
        st_n    = ST_HRST;
        ev_hard = 1'b1;
      end
    end else begin
      case (st_q)
        ST_RUN: begin
          if (stop_req) st_n = ST_STOP;
          if (pend_q) begin
            irq_n  = irq_enable;
            pend_n = 1'b0;
          end
        end
        ST_STOP: begin
          if (wdt_timeout) begin
            ev_wdt = 1'b1;
            st_n   = ST_RECOVER;
            cnt_n  = '0;
            pend_n = wdt_irq_mode;
          end else if (pin_wake) begin
            ev_pin = 1'b1;
            st_n   = ST_RECOVER;
            cnt_n  = '0;
          end
        end
        ST_RECOVER: begin
          if (cnt_q == CNT_LAST) begin
            st_n   = ST_VEC0;
            done_n = 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_HRST: st_n = ST_VEC0;
        ST_VEC0: st_n = ST_VEC1;
        ST_VEC1: st_n = ST_RUN;
        default: st_n = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
      done_q <= done_n;
      irq_q  <= irq_n;
    end
  end

  assign in_stop      = (st_q == ST_STOP);
  assign frz          = (st_q == ST_STOP) || (st_q == ST_RECOVER);
  assign snap_take    = (st_q == ST_RUN) && stop_req && !hard_req;
  assign sys_reset    = (st_q == ST_HRST);
  assign recover_done = done_q;
  assign wdt_irq      = irq_q;
  assign vec_valid    = (st_q == ST_VEC0) || (st_q == ST_VEC1);
  assign vec_addr     = (st_q == ST_VEC1) ? VEC_ADDR + 1'b1 : VEC_ADDR;

  assert_vec_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_VEC0 && !hard_req) |=> (st_q == ST_VEC1));
  assert_irq_after_recover_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !(st_q == ST_STOP || st_q == ST_RECOVER));
  assert_reset_no_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HRST) |-> !done_q);
  assert_recover_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECOVER && !hard_req) |=> (st_q == ST_RECOVER || st_q == ST_VEC0));
endmodule

// File: rtl/swc_status.sv
`timescale 1ns/1ps
module swc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic status_rd,
  input  logic ev_wdt,
  input  logic ev_pin,
  input  logic ev_hard,
  output logic stat_stop,
  output logic stat_wdt,
  output logic stat_hard
);
  logic stop_q, stop_n, wdt_q, wdt_n, hard_q, hard_n;

  always_comb begin
    stop_n = stop_q;
    wdt_n  = wdt_q;
    hard_n = hard_q;
    if (status_rd) begin
      stop_n = 1'b0;
      wdt_n  = 1'b0;
      hard_n = 1'b0;
    end
    if (ev_wdt) begin
      wdt_n  = 1'b1;
      stop_n = 1'b1;
    end
    if (ev_pin) stop_n = 1'b1;
    if (ev_hard) begin
      stop_n = 1'b0;
      hard_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      wdt_q  <= 1'b0;
      hard_q <= 1'b0;
    end else begin
      stop_q <= stop_n;
      wdt_q  <= wdt_n;
      hard_q <= hard_n;
    end
  end

  assign stat_stop = stop_q;
  assign stat_wdt  = wdt_q;
  assign stat_hard = hard_q;

  assert_wdt_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdt |=> (wdt_q && stop_q));
  assert_hard_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hard |=> (hard_q && !stop_q));
  assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !ev_wdt && !ev_pin && !ev_hard) |=> !(wdt_q || stop_q || hard_q));
endmodule

// File: rtl/stop_wake_ctrl.sv
`timescale 1ns/1ps
module stop_wake_ctrl #(
  parameter int unsigned   N_PINS   = 8,
  parameter int unsigned   DELAY    = 64,
  parameter int unsigned   AW       = 16,
  parameter logic [AW-1:0] VEC_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req,
  input  logic              wdt_timeout,
  input  logic              wdt_irq_mode,
  input  logic              irq_enable,
  input  logic [N_PINS-1:0] gpio_wake_en,
  input  logic [N_PINS-1:0] gpio_pin,
  input  logic              ext_reset_n,
  input  logic              dbg_n,
  input  logic              status_rd,
  output logic              sys_reset,
  output logic              recover_done,
  output logic              wdt_irq,
  output logic              vec_valid,
  output logic [AW-1:0]     vec_addr,
  output logic              in_stop,
  output logic [N_PINS-1:0] port_in,
  output logic [N_PINS-1:0] pin_irq,
  output logic              stat_stop,
  output logic              stat_wdt,
  output logic              stat_hard
);
  logic rst_s1_q, rst_s2_q;
  logic rst_int_n;
  logic [N_PINS-1:0] pin_s;
  logic [1:0] hpin_s;
  logic hard_req, pin_wake, frz, snap_take;
  logic ev_wdt, ev_pin, ev_hard;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  swc_sync #(.W(N_PINS), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .rst_n(rst_int_n), .d(gpio_pin), .q(pin_s));

  swc_sync #(.W(2), .RST_VAL(1'b1)) u_hard_sync (
    .clk(clk), .rst_n(rst_int_n), .d({ext_reset_n, dbg_n}), .q(hpin_s));

  assign hard_req = !hpin_s[1] || !hpin_s[0];

  swc_pin_watch #(.N_PINS(N_PINS)) u_watch (
    .clk(clk), .rst_n(rst_int_n), .pin_s(pin_s), .wake_en(gpio_wake_en),
    .snap_take(snap_take), .frz(frz), .wake_hit(pin_wake),
    .port_in(port_in), .pin_irq(pin_irq));

  swc_seq #(.DELAY(DELAY), .AW(AW), .VEC_ADDR(VEC_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .stop_req(stop_req), .wdt_timeout(wdt_timeout),
    .wdt_irq_mode(wdt_irq_mode), .irq_enable(irq_enable), .pin_wake(pin_wake),
    .hard_req(hard_req), .in_stop(in_stop), .frz(frz), .snap_take(snap_take),
    .sys_reset(sys_reset), .recover_done(recover_done), .wdt_irq(wdt_irq),
    .vec_valid(vec_valid), .vec_addr(vec_addr),
    .ev_wdt(ev_wdt), .ev_pin(ev_pin), .ev_hard(ev_hard));

  swc_status u_status (
    .clk(clk), .rst_n(rst_int_n), .status_rd(status_rd),
    .ev_wdt(ev_wdt), .ev_pin(ev_pin), .ev_hard(ev_hard),
    .stat_stop(stat_stop), .stat_wdt(stat_wdt), .stat_hard(stat_hard));

  assert_stop_entry_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stop_req && !in_stop && !frz && !vec_valid && !sys_reset && !hard_req) |=> in_stop);
endmodule

// File: tb/test_stop_wake_ctrl.sv
`timescale 1ns/1ps
module test_stop_wake_ctrl;
  localparam int N = 8;
  localparam int DLY = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, wdt_timeout = 0, wdt_irq_mode = 0, irq_enable = 0;
  logic [N-1:0] gpio_wake_en = '0, gpio_pin = '0;
  logic ext_reset_n = 1, dbg_n = 1, status_rd = 0;
  logic sys_reset, recover_done, wdt_irq, vec_valid, in_stop;
  logic [15:0] vec_addr;
  logic [N-1:0] port_in, pin_irq;
  logic stat_stop, stat_wdt, stat_hard;

  stop_wake_ctrl #(.N_PINS(N), .DELAY(DLY)) i_stop_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wdt_timeout(wdt_timeout),
    .wdt_irq_mode(wdt_irq_mode), .irq_enable(irq_enable),
    .gpio_wake_en(gpio_wake_en), .gpio_pin(gpio_pin), .ext_reset_n(ext_reset_n),
    .dbg_n(dbg_n), .status_rd(status_rd), .sys_reset(sys_reset),
    .recover_done(recover_done), .wdt_irq(wdt_irq), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .in_stop(in_stop), .port_in(port_in), .pin_irq(pin_irq),
    .stat_stop(stat_stop), .stat_wdt(stat_wdt), .stat_hard(stat_hard));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, t_fall = 0, t_done = 0, t_irq = 0;
  int n_done = 0, n_rst = 0, n_irq = 0, nv = 0;
  logic prev_stop = 0;
  logic [N-1:0] pirq_or = '0;
  logic [15:0] vlog [4];

  // monitor samples on the falling edge, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (prev_stop && !in_stop) t_fall = cyc;
    prev_stop = in_stop;
    if (recover_done) begin n_done++; t_done = cyc; end
    if (sys_reset) n_rst++;
    if (wdt_irq) begin n_irq++; t_irq = cyc; end
    pirq_or = pirq_or | pin_irq;
    if (vec_valid && nv < 4) begin vlog[nv] = vec_addr; nv++; end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    n_done = 0; n_rst = 0; n_irq = 0; nv = 0; pirq_or = '0;
    t_fall = 0; t_done = 0; t_irq = 0;
  endtask

  task automatic rd_status();
    status_rd = 1; step(); status_rd = 0; step();
  endtask

  // {kind[1:0] 0=wdt 1=pin 2=ext 3=dbg, mode, irqen, glitch, en[7:0], tog[7:0],
  //  exp_wdt, exp_stop, exp_hard, exp_irq}
  localparam logic [24:0] TBL [8] = '{
    {2'd0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b1, 1'b0, 8'h01, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b1, 1'b0, 8'h01, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b1, 1'b1, 8'h80, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd3, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog R7 actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(5);
    // R1 reset state
    chk(!in_stop && !sys_reset && !recover_done && !wdt_irq && !vec_valid, "R1 outputs",
        {in_stop, sys_reset, recover_done, wdt_irq, vec_valid}, 0);
    chk(!stat_stop && !stat_wdt && !stat_hard, "R1 status", {stat_stop, stat_wdt, stat_hard}, 0);

    for (int v = 0; v < 8; v++) begin
      logic [1:0] kind;
      logic glitch, e_wdt, e_stop, e_hard, e_irq;
      logic [N-1:0] tog, base, exp_port;
      kind = TBL[v][24:23];
      glitch = TBL[v][20];
      tog = TBL[v][11:4];
      {e_wdt, e_stop, e_hard, e_irq} = TBL[v][3:0];
      base = gpio_pin;
      rd_status();
      wdt_irq_mode = TBL[v][22];
      irq_enable = TBL[v][21];
      gpio_wake_en = TBL[v][19:12];
      mon_clear();
      stop_req = 1; step(); stop_req = 0; step();
      chk(in_stop == 1, "R2 stop entry", in_stop, 1);
      case (kind)
        2'd0: begin wdt_timeout = 1; step(); wdt_timeout = 0; end
        2'd1: begin
          gpio_pin = base ^ tog;
          if (glitch) begin step(4); gpio_pin = base; end
        end
        2'd2: begin ext_reset_n = 0; step(6); ext_reset_n = 1; end
        default: begin dbg_n = 0; step(6); dbg_n = 1; end
      endcase
      step(DLY + 40);
      exp_port = glitch ? base : (base ^ tog);
      chk(n_done == (e_hard ? 0 : 1), "R7 done count", n_done, e_hard ? 0 : 1);
      if (!e_hard) chk(t_done - t_fall == DLY, "R7 delay", t_done - t_fall, DLY);
      chk((n_rst > 0) == e_hard, "R6 sys_reset", n_rst, e_hard);
      chk(n_irq == int'(e_irq), "R4 irq count", n_irq, e_irq);
      if (e_irq) chk(t_irq > t_done, "R4 irq order", t_irq, t_done + 1);
      chk(nv == 2 && vlog[0] == 16'h2 && vlog[1] == 16'h3, "R8 vector",
          {nv[7:0], vlog[0][7:0], vlog[1][7:0]}, 24'h020203);
      chk({stat_wdt, stat_stop, stat_hard} == {e_wdt, e_stop, e_hard}, "R3 R5 R6 status",
          {stat_wdt, stat_stop, stat_hard}, {e_wdt, e_stop, e_hard});
      chk(port_in == exp_port, "R9 port", port_in, exp_port);
      chk(pirq_or == (glitch ? '0 : tog), "R9 pin_irq", pirq_or, glitch ? 0 : tog);
    end

    // R5 disabled pin ignored, then watchdog exits
    rd_status();
    gpio_wake_en = 8'h01;
    mon_clear();
    stop_req = 1; step(); stop_req = 0; step();
    gpio_pin = gpio_pin ^ 8'h04;
    step(20);
    chk(in_stop == 1 && n_done == 0, "R5 disabled pin", {in_stop, n_done[3:0]}, 5'h10);
    chk(port_in[2] != gpio_pin[2], "R9 frozen", port_in[2], !gpio_pin[2]);
    wdt_irq_mode = 0;
    wdt_timeout = 1; step(); wdt_timeout = 0;
    step(DLY + 20);
    chk(n_done == 1, "R3 wdt exit", n_done, 1);

    // R7 wake events during recovery are ignored
    rd_status();
    gpio_wake_en = 8'h02;
    mon_clear();
    stop_req = 1; step(); stop_req = 0; step();
    gpio_pin = gpio_pin ^ 8'h02;
    step(10);
    wdt_timeout = 1; step(); wdt_timeout = 0;
    gpio_pin = gpio_pin ^ 8'h02;
    step(DLY + 30);
    chk(n_done == 1 && t_done - t_fall == DLY, "R7 ignore during delay",
        t_done - t_fall, DLY);
    chk(stat_wdt == 0 && stat_stop == 1, "R7 flags", {stat_wdt, stat_stop}, 2'b01);

    // R10 read clears
    rd_status();
    chk(!stat_stop && !stat_wdt && !stat_hard, "R10 clear",
        {stat_stop, stat_wdt, stat_hard}, 0);

    summary();
    $finish;
  end
endmodule